// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep synchronous FIFO out of several identical shallow slices. Each slice has its own small storage ring, its own occupancy counter and its own local flags. The slices are joined in a loop by two tokens. The write token marks the slice that takes the next incoming word. The read token marks the slice that supplies the next outgoing word. A slice gives up a token when it uses the last address of its storage. The token then moves to the next slice around the loop, so words spread across the slices in strict arrival order.

Strap inputs choose the slice that holds both tokens when reset ends; the wrapper straps slice 0 for this. Write and read enables go to every slice in parallel, and only the token holder acts on them. The wrapper takes read data from the slice that holds the read token. It combines the per-slice flags into chain-level empty, full, almost-empty and almost-full flags. The almost thresholds can be changed at run time by a single load strobe, which reaches every slice in the same cycle. Reset is asserted asynchronously, active low, and is released on the clock.

Top module: `tokring_fifo`

## Requirements
- R1: While reset is held and after it is released with no traffic, empty=1, full=0, almost_empty=1 and almost_full=0.
- R2: Words leave in exactly the order they were accepted, including across slice boundaries. A word is accepted on a clock edge where wr_en=1 and fewer than N_SLICE*DEPTH words are stored. While empty=0, rd_data shows the oldest stored word, and a rising edge with rd_en=1 removes it.
- R3: A write attempted while N_SLICE*DEPTH words are stored is dropped. Neither the stored contents nor the count change.
- R4: A read attempted while nothing is stored has no effect. A word written afterwards is read back unchanged.
- R5: empty is 1 exactly when no word is stored in the chain.
- R6: full is 1 exactly when N_SLICE*DEPTH words are stored.
- R7: almost_empty is 1 exactly when every slice holds no more words than the empty-side threshold. A word with arrival index k (counting from 0 after reset) lives in slice (k/DEPTH) mod N_SLICE.
- R8: almost_full is 1 exactly when, in every slice, the stored count plus the full-side threshold is at least DEPTH. The thresholds reset to 2 and 2.
- R9: A cycle with thr_load=1 copies thr_ae and thr_af into the thresholds of every slice at that clock edge. The flags use the new values from the next cycle on.
- R10: A read and a write in the same cycle are both performed when the chain is neither empty nor full, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all slices |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request, removes the word shown on rd_data |
| rd_data | output | DW | Oldest stored word, taken from the read-token slice |
| thr_load | input | 1 | Load strobe for both almost thresholds, shared by all slices |
| thr_ae | input | clog2(DEPTH+1) | Empty-side threshold value to load |
| thr_af | input | clog2(DEPTH+1) | Full-side threshold value to load |
| empty | output | 1 | Chain holds no word |
| full | output | 1 | Chain holds N_SLICE*DEPTH words |
| almost_empty | output | 1 | Combined almost-empty flag of all slices |
| almost_full | output | 1 | Combined almost-full flag of all slices |

## Verification
The bench streams more words than one slice can hold. This makes both tokens cross the slice boundary and wrap back to the first slice. A token that is passed too early, too late or lost shows up as words out of order or as a stuck flag. The bench fills the chain completely and then writes once more. A design that accepted this write would return an extra word or overwrite the oldest one. It also reads an empty chain, where a wrong design would move the read pointer and return stale data later. The almost flags are compared with a per-slice occupancy model after threshold loads. A design that formed them from the total count instead of from each slice would disagree whenever the slices are unevenly filled.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic aempty;
    logic afull;
  } slice_flags_t;
endpackage

// File: rtl/tokring_tok_cell.sv
// Holds one ownership token; passes it on when the last address is used.
module tokring_tok_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic is_first,
  input  logic tok_in,
  input  logic fire,
  input  logic at_last,
  output logic own,
  output logic tok_out
);
  logic own_d;

  assign tok_out = own & fire & at_last;

  always_comb begin
    own_d = (own & ~tok_out) | tok_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own <= is_first;
    else        own <= own_d;
  end
endmodule

// File: rtl/tokring_store.sv
// Local storage ring of one slice; asynchronous read port.
module tokring_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tokring_slice.sv
module tokring_slice
  import tokring_pkg::*;
#(
  parameter int DW     = 18,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_n,
  input  logic          wtok_in,
  output logic          wtok_out,
  input  logic          rtok_in,
  output logic          rtok_out,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          thr_load,
  input  logic [CW-1:0] thr_ae,
  input  logic [CW-1:0] thr_af,
  output logic          wr_own,
  output logic          rd_own,
  output slice_flags_t  flags
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, wptr_d, rptr, rptr_d;
  logic [CW-1:0] cnt, cnt_d, ae_thr, ae_thr_d, af_thr, af_thr_d;
  logic          wr_fire, rd_fire, empty_l, full_l;

  assign empty_l = (cnt == '0);
  assign full_l  = (cnt == CW'(DEPTH));
  assign wr_fire = wr_en & wr_own & ~full_l;
  assign rd_fire = rd_en & rd_own & ~empty_l;

  tokring_tok_cell u_wtok (
    .clk(clk), .rst_n(rst_n), .is_first(~first_n), .tok_in(wtok_in),
    .fire(wr_fire), .at_last(wptr == LAST), .own(wr_own), .tok_out(wtok_out)
  );

  tokring_tok_cell u_rtok (
    .clk(clk), .rst_n(rst_n), .is_first(~first_n), .tok_in(rtok_in),
    .fire(rd_fire), .at_last(rptr == LAST), .own(rd_own), .tok_out(rtok_out)
  );

  tokring_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_data)
  );

  always_comb begin
    wptr_d   = wptr;
    rptr_d   = rptr;
    ae_thr_d = ae_thr;
    af_thr_d = af_thr;
    if (wr_fire) wptr_d = (wptr == LAST) ? '0 : wptr + AW'(1);
    if (rd_fire) rptr_d = (rptr == LAST) ? '0 : rptr + AW'(1);
    cnt_d = cnt + CW'(wr_fire) - CW'(rd_fire);
    if (thr_load) begin
      ae_thr_d = thr_ae;
      af_thr_d = thr_af;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      ae_thr <= CW'(AE_DEF);
      af_thr <= CW'(AF_DEF);
    end else begin
      wptr   <= wptr_d;
      rptr   <= rptr_d;
      cnt    <= cnt_d;
      ae_thr <= ae_thr_d;
      af_thr <= af_thr_d;
    end
  end

  always_comb begin
    flags.empty  = empty_l;
    flags.full   = full_l;
    flags.aempty = (cnt <= ae_thr);
    flags.afull  = (({1'b0, cnt} + {1'b0, af_thr}) >= (CW + 1)'(DEPTH));
  end
endmodule

// File: rtl/tokring_fifo.sv
module tokring_fifo
  import tokring_pkg::*;
#(
  parameter int N_SLICE = 2,
  parameter int DEPTH   = 16,
  parameter int DW      = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  input  logic                         thr_load,
  input  logic [$clog2(DEPTH+1)-1:0]   thr_ae,
  input  logic [$clog2(DEPTH+1)-1:0]   thr_af,
  output logic                         empty,
  output logic                         full,
  output logic                         almost_empty,
  output logic                         almost_full
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [N_SLICE-1:0] wt_out, rt_out, wr_own_v, rd_own_v;
  logic [DW-1:0]      sl_rd [N_SLICE];
  slice_flags_t       sl_fl [N_SLICE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    localparam int PREV = (i == 0) ? N_SLICE - 1 : i - 1;
    tokring_slice #(.DW(DW), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_sync_n), .first_n(i != 0),
      .wtok_in(wt_out[PREV]), .wtok_out(wt_out[i]),
      .rtok_in(rt_out[PREV]), .rtok_out(rt_out[i]),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(sl_rd[i]),
      .thr_load(thr_load), .thr_ae(thr_ae), .thr_af(thr_af),
      .wr_own(wr_own_v[i]), .rd_own(rd_own_v[i]), .flags(sl_fl[i])
    );
  end

  always_comb begin
    rd_data      = '0;
    empty        = 1'b1;
    full         = 1'b1;
    almost_empty = 1'b1;
    almost_full  = 1'b1;
    for (int i = 0; i < N_SLICE; i++) begin
      rd_data      = rd_data | (sl_rd[i] & {DW{rd_own_v[i]}});
      empty        = empty & sl_fl[i].empty;
      full         = full & sl_fl[i].full;
      almost_empty = almost_empty & sl_fl[i].aempty;
      almost_full  = almost_full & sl_fl[i].afull;
    end
  end
endmodule

// File: rtl/tokring_chk.sv
module tokring_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic         empty,
  input logic         full,
  input logic         almost_empty,
  input logic         almost_full,
  input logic [N-1:0] wr_own,
  input logic [N-1:0] rd_own
);
  assert_one_wtok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_own) == 1);
  assert_one_rtok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_own) == 1);
  assert_not_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty);
  assert_ae_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);
  assert_af_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full);
endmodule

bind tokring_fifo tokring_chk #(.N(N_SLICE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .empty(empty), .full(full), .almost_empty(almost_empty),
  .almost_full(almost_full), .wr_own(wr_own_v), .rd_own(rd_own_v)
);

// File: tb/tb_tokring_fifo.sv
`timescale 1ns/1ps
module tb_tokring_fifo;
  localparam int N   = 2;
  localparam int D   = 16;
  localparam int CAP = N * D;
  localparam int DW  = 18;
  localparam int CW  = $clog2(D + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, wr_en, rd_en, thr_load;
  logic [DW-1:0] wr_data, rd_data;
  logic [CW-1:0] thr_ae, thr_af;
  logic          empty, full, almost_empty, almost_full;

  tokring_fifo #(.N_SLICE(N), .DEPTH(D), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .thr_load(thr_load),
    .thr_ae(thr_ae), .thr_af(thr_af), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int nchk = 0, nerr = 0;
  int wtot = 0, rtot = 0;
  int ae_m = 2, af_m = 2;
  logic [DW-1:0] expq [64];

  function automatic int slice_cnt(int s);
    int c = 0;
    for (int k = rtot; k < wtot; k++) if (((k / D) % N) == s) c++;
    return c;
  endfunction

  function automatic bit m_ae();
    bit r = 1'b1;
    for (int s = 0; s < N; s++) if (slice_cnt(s) > ae_m) r = 1'b0;
    return r;
  endfunction

  function automatic bit m_af();
    bit r = 1'b1;
    for (int s = 0; s < N; s++) if (slice_cnt(s) + af_m < D) r = 1'b0;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(string ctx);
    chk({ctx, " R5 empty"}, int'(empty), int'(wtot == rtot));
    chk({ctx, " R6 full"}, int'(full), int'(wtot - rtot == CAP));
    chk({ctx, " R7 almost_empty"}, int'(almost_empty), int'(m_ae()));
    chk({ctx, " R8 almost_full"}, int'(almost_full), int'(m_af()));
  endtask

  // Called at a falling edge; drives one cycle and checks after it.
  task automatic cycle(bit w, logic [DW-1:0] d, bit r, string ctx);
    int  cnt = wtot - rtot;
    bit  wa = w && (cnt < CAP);
    bit  ra = r && (cnt > 0);
    wr_en = w; wr_data = d; rd_en = r;
    #1;
    if (ra) chk({ctx, " R2 rd_data"}, int'(rd_data), int'(expq[rtot % 64]));
    @(posedge clk);
    if (wa) begin expq[wtot % 64] = d; wtot++; end
    if (ra) rtot++;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_flags(ctx);
  endtask

  task automatic load_thr(int ae, int af);
    thr_load = 1'b1; thr_ae = CW'(ae); thr_af = CW'(af);
    @(posedge clk);
    ae_m = ae; af_m = af;
    @(negedge clk);
    thr_load = 1'b0;
    check_flags("R9 load");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'd11);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    thr_load = 1'b0; thr_ae = '0; thr_af = '0;
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", int'(empty), 1);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 ae in reset", int'(almost_empty), 1);
    chk("R1 af in reset", int'(almost_full), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_flags("R1 after release");

    // R4: read on empty, then a single word round trip
    cycle(1'b0, '0, 1'b1, "R4 empty read");
    cycle(1'b1, 18'h2A5, 1'b0, "R4 write");
    cycle(1'b0, '0, 1'b1, "R4 readback");

    // R2/R6: fill the whole chain across slice boundaries
    for (int i = 0; i < CAP; i++) cycle(1'b1, DW'(i * 37) ^ 18'h15A5A, 1'b0, "R6 fill");
    chk("R6 full at capacity", int'(full), 1);
    cycle(1'b1, 18'h3FFFF, 1'b0, "R3 write when full");
    cycle(1'b1, 18'h3FFFE, 1'b1, "R3 write+read when full");
    for (int i = 0; i < CAP; i++) cycle(1'b0, '0, 1'b1, "R2 drain");
    chk("R5 empty after drain", int'(empty), 1);
    cycle(1'b0, '0, 1'b1, "R4 read when empty");
    cycle(1'b1, 18'h00C3, 1'b1, "R4 write+read when empty");
    cycle(1'b0, '0, 1'b1, "R4 readback after empty");

    // R10: simultaneous traffic in mid occupancy
    for (int i = 0; i < 5; i++) cycle(1'b1, DW'(18'h1000 + i), 1'b0, "R10 prefill");
    for (int i = 0; i < 40; i++) cycle(1'b1, DW'(18'h2000 + i), 1'b1, "R10 both");
    chk("R10 count unchanged", wtot - rtot, 5);

    // R9: threshold loads take effect in every slice
    load_thr(5, 0);
    load_thr(4, 12);
    load_thr(0, 16);

    // random phases with varying write bias
    for (int ph = 0; ph < 4; ph++) begin
      int pw = (ph == 0) ? 80 : (ph == 2) ? 20 : 50;
      for (int i = 0; i < 400; i++) begin
        if (($urandom % 50) == 0) load_thr($urandom % (D + 1), $urandom % (D + 1));
        cycle(($urandom % 100) < pw, DW'($urandom), ($urandom % 100) < (100 - pw + 10),
              "R2 random");
      end
    end
    while (wtot != rtot) cycle(1'b0, '0, 1'b1, "R2 final drain");
    check_flags("R5 end");
    finish_run();
  end
endmodule